// File: doc/BRIEF.md
# Serial Peripheral Sleep Clock Gate

This block sits beside a serial peripheral and, on every cycle of an always-on clock, decides three things from the system sleep state and the peripheral's role. It decides whether the peripheral's core clock may keep running, whether incoming data must be thrown away, and whether a wake-up request goes to the power manager. As a master, the peripheral may keep its clock through standby. If it is not configured to do so, the clock is withdrawn only once the current transfer has drained. As a slave that is not configured to run in standby, the peripheral loses its clock at once and every reception is flagged for discard, including a frame already in flight.

All three outputs come from registers, so each reflects the inputs sampled on the previous rising edge. The wake request is a one-cycle pulse. It fires on the first cycle that a wake condition appears, and it does not fire again while that condition stays true.

Top module: `srl_sleep_gate`

## Requirements
- R1: `sleep_mode` is coded 2'b00 active, 2'b01 idle, 2'b10 standby, and 2'b11 is handled as active. In idle, `core_clk_en` is 1 on the cycle after the mode is sampled, in both roles and for either `run_stby` value.
- R2: A master in standby with `run_stby`=1 keeps `core_clk_en` at 1.
- R3: A master in standby with `run_stby`=0 keeps `core_clk_en` at 1 while `xfer_busy` is sampled 1. The clock is dropped on the cycle after `xfer_busy` is sampled 0, and it stays off for the rest of that standby period even if `xfer_busy` rises again.
- R4: A slave in standby with `run_stby`=0 has `core_clk_en`=0 and `rx_drop`=1 from the next cycle, whatever the value of `xfer_busy`.
- R5: A slave in standby with `run_stby`=1 has `core_clk_en`=1 and `rx_drop`=0.
- R6: In idle (either role), or as a master in standby, any set bit of `irq_req` is a wake condition.
- R7: A slave in standby with `run_stby`=1 treats `rx_done`=1 as its only wake condition, and `irq_req` has no effect.
- R8: `wake_req` pulses high for exactly one cycle, on the cycle after a wake condition first becomes true. A condition that is held produces no second pulse.
- R9: When the mode is active, the next cycle has `core_clk_en`=1, `rx_drop`=0 and `wake_req`=0.
- R10: While `rst_n` is sampled 0, the next cycle has `core_clk_en`=1, `rx_drop`=0 and `wake_req`=0.
- R11: A slave in standby with `run_stby`=0 raises no wake request, even when `rx_done` or `irq_req` are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_mode | input | 2 | System sleep state (active, idle, standby) |
| run_stby | input | 1 | Keep running in standby |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| xfer_busy | input | 1 | A transfer is in progress |
| rx_done | input | 1 | Receive-complete event |
| irq_req | input | IRQ_W | Peripheral interrupt requests |
| core_clk_en | output | 1 | Enable for the peripheral core clock |
| rx_drop | output | 1 | Discard received data |
| wake_req | output | 1 | One-cycle wake request pulse |

## Verification
The assertions assume that every input is settled at the rising edge of `clk`. They also assume that `rst_n` is held low for at least one edge before the first checked cycle, so that the registered gate and the wake history start from known values. The bench respects this by changing inputs only on the falling edge. It holds reset for several cycles with inputs that are deliberately busy. It then walks through directed role, mode and busy sequences, including the reserved mode code, before a long stretch of random stimulus drawn from all four mode codes.

// File: rtl/sgate_pkg.sv
package sgate_pkg;

    typedef enum logic [1:0] {
        SLP_ACTIVE = 2'b00,
        SLP_IDLE   = 2'b01,
        SLP_STBY   = 2'b10,
        SLP_RSVD   = 2'b11
    } slp_mode_e;

    typedef struct packed {
        logic clk_en;
        logic drop;
    } gate_st_t;

    typedef struct packed {
        logic cond;
        logic pulse;
    } wake_st_t;

    localparam gate_st_t GATE_RST = '{clk_en: 1'b1, drop: 1'b0};
    localparam wake_st_t WAKE_RST = '{cond: 1'b0, pulse: 1'b0};

endpackage

// File: rtl/sgate_clk_ctl.sv
module sgate_clk_ctl
    import sgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       run_stby_i,
    input  logic       master_i,
    input  logic       xfer_busy_i,
    output logic       clk_en_o,
    output logic       drop_o
);

    gate_st_t  st_d, st_q;
    slp_mode_e mode;

    assign mode = slp_mode_e'(mode_i);

    always_comb begin
        st_d = GATE_RST;
        if (mode == SLP_STBY) begin
            if (master_i) begin
                // hold the clock only while a transfer that began before the gate drains
                st_d.clk_en = run_stby_i | (st_q.clk_en & xfer_busy_i);
                st_d.drop   = 1'b0;
            end else begin
                st_d.clk_en = run_stby_i;
                st_d.drop   = ~run_stby_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= GATE_RST;
        else        st_q <= st_d;
    end

    assign clk_en_o = st_q.clk_en;
    assign drop_o   = st_q.drop;

    p_idle_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SLP_IDLE) |=> clk_en_o);

    p_mst_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SLP_STBY && master_i && run_stby_i) |=> clk_en_o);

    p_mst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SLP_STBY && master_i && clk_en_o && xfer_busy_i) |=> clk_en_o);

    p_mst_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SLP_STBY && master_i && !run_stby_i && !xfer_busy_i) |=> !clk_en_o);

    p_slv_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SLP_STBY && !master_i && !run_stby_i) |=> (drop_o && !clk_en_o));

    p_slv_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SLP_STBY && !master_i && run_stby_i) |=> (clk_en_o && !drop_o));

    p_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SLP_ACTIVE || mode == SLP_RSVD) |=> (clk_en_o && !drop_o));

    p_reset_gate_r10: assert property (@(posedge clk)
        !rst_n |=> (clk_en_o && !drop_o));

endmodule

// File: rtl/sgate_wake.sv
module sgate_wake
    import sgate_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             run_stby_i,
    input  logic             master_i,
    input  logic             rx_done_i,
    input  logic [IRQ_W-1:0] irq_i,
    output logic             wake_o
);

    wake_st_t  st_d, st_q;
    slp_mode_e mode;
    logic      any_irq;
    logic      cond;

    assign mode    = slp_mode_e'(mode_i);
    assign any_irq = |irq_i;

    always_comb begin
        case (mode)
            SLP_IDLE: cond = any_irq;
            SLP_STBY: cond = master_i ? any_irq : (run_stby_i & rx_done_i);
            default:  cond = 1'b0;
        endcase
        st_d.cond  = cond;
        st_d.pulse = cond & ~st_q.cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WAKE_RST;
        else        st_q <= st_d;
    end

    assign wake_o = st_q.pulse;

    p_mst_irq_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && (mode == SLP_IDLE || mode == SLP_STBY) && any_irq && !st_q.cond)
        |=> wake_o);

    p_slv_rx_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && mode == SLP_STBY && run_stby_i && !rx_done_i) |=> !wake_o);

    p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    p_active_nowake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SLP_ACTIVE || mode == SLP_RSVD) |=> !wake_o);

    p_reset_wake_r10: assert property (@(posedge clk)
        !rst_n |=> !wake_o);

    p_slv_drop_nowake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && mode == SLP_STBY && !run_stby_i) |=> !wake_o);

endmodule

// File: rtl/srl_sleep_gate.sv
module srl_sleep_gate #(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sleep_mode,
    input  logic             run_stby,
    input  logic             is_master,
    input  logic             xfer_busy,
    input  logic             rx_done,
    input  logic [IRQ_W-1:0] irq_req,
    output logic             core_clk_en,
    output logic             rx_drop,
    output logic             wake_req
);

    sgate_clk_ctl u_clk_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (sleep_mode),
        .run_stby_i  (run_stby),
        .master_i    (is_master),
        .xfer_busy_i (xfer_busy),
        .clk_en_o    (core_clk_en),
        .drop_o      (rx_drop)
    );

    sgate_wake #(.IRQ_W(IRQ_W)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (sleep_mode),
        .run_stby_i (run_stby),
        .master_i   (is_master),
        .rx_done_i  (rx_done),
        .irq_i      (irq_req),
        .wake_o     (wake_req)
    );

    // a drop flag never coexists with a running core clock
    p_drop_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |-> !core_clk_en);

endmodule

// File: tb/tb_srl_sleep_gate.sv
module tb_srl_sleep_gate;

    localparam int CLK_PERIOD = 10;
    localparam int IRQ_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       sleep_mode = 2'b00;
    logic             run_stby = 1'b0;
    logic             is_master = 1'b0;
    logic             xfer_busy = 1'b0;
    logic             rx_done = 1'b0;
    logic [IRQ_W-1:0] irq_req = '0;
    logic             core_clk_en, rx_drop, wake_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model state
    bit m_en   = 1'b1;
    bit m_cond = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srl_sleep_gate #(.IRQ_W(IRQ_W)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_mode(sleep_mode), .run_stby(run_stby),
        .is_master(is_master), .xfer_busy(xfer_busy), .rx_done(rx_done),
        .irq_req(irq_req), .core_clk_en(core_clk_en), .rx_drop(rx_drop),
        .wake_req(wake_req)
    );

    task automatic chk(input string tag, input string what, input logic act, input bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic [1:0] md, input bit run, input bit mst, input bit busy,
                        input bit rxd, input logic [IRQ_W-1:0] irq, input string wtag = "");
        bit    e_en, e_drop, e_wake, cond;
        string gtag, ktag;
        @(negedge clk);
        sleep_mode = md; run_stby = run; is_master = mst;
        xfer_busy = busy; rx_done = rxd; irq_req = irq;
        // behavioural expectation from the requirements
        if (md == 2'b10) begin
            if (mst) begin
                e_en = run || (m_en && busy);
                gtag = run ? "R2" : "R3";
            end else begin
                e_en = run;
                gtag = run ? "R5" : "R4";
            end
            e_drop = !mst && !run;
        end else begin
            e_en   = 1'b1;
            e_drop = 1'b0;
            gtag   = (md == 2'b01) ? "R1" : "R9";
        end
        if (md == 2'b01) begin
            cond = (irq != 0); ktag = "R6";
        end else if (md == 2'b10 && mst) begin
            cond = (irq != 0); ktag = "R6";
        end else if (md == 2'b10) begin
            cond = run && rxd; ktag = run ? "R7" : "R11";
        end else begin
            cond = 1'b0; ktag = "R9";
        end
        if (wtag != "") ktag = wtag;
        e_wake = cond && !m_cond;
        m_cond = cond;
        m_en   = e_en;
        @(posedge clk);
        #1;
        chk(gtag, "core_clk_en", core_clk_en, e_en);
        chk(gtag, "rx_drop", rx_drop, e_drop);
        chk(ktag, "wake_req", wake_req, e_wake);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            $display("FAIL all watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset with hostile inputs (slave, standby, no run-in-standby, irq set)
        sleep_mode = 2'b10; is_master = 1'b0; run_stby = 1'b0; irq_req = 8'hff; rx_done = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "core_clk_en", core_clk_en, 1'b1);
        chk("R10", "rx_drop", rx_drop, 1'b0);
        chk("R10", "wake_req", wake_req, 1'b0);
        sleep_mode = 2'b00; irq_req = '0; rx_done = 1'b0;
        rst_n = 1'b1;
        m_en = 1'b1; m_cond = 1'b0;

        // R1: idle keeps the clock in both roles
        step(2'b01, 0, 1, 0, 0, '0);
        step(2'b01, 0, 0, 0, 0, '0);
        step(2'b01, 1, 0, 0, 0, '0);
        // R2: master standby with run-in-standby
        step(2'b10, 1, 1, 0, 0, '0);
        step(2'b10, 1, 1, 0, 0, '0);
        // R3: master standby, clock held through the transfer then gated
        step(2'b00, 0, 1, 0, 0, '0);
        step(2'b10, 0, 1, 1, 0, '0);
        step(2'b10, 0, 1, 1, 0, '0);
        step(2'b10, 0, 1, 0, 0, '0);
        step(2'b10, 0, 1, 1, 0, '0);
        step(2'b10, 0, 1, 1, 0, '0);
        // R9: back to active restores the clock
        step(2'b00, 0, 1, 0, 0, '0);
        // R4: slave drops even mid-transfer
        step(2'b10, 0, 0, 1, 0, '0);
        step(2'b10, 0, 0, 1, 0, '0);
        // R11: drop state ignores rx_done and irq
        step(2'b10, 0, 0, 1, 1, 8'h81);
        step(2'b10, 0, 0, 0, 1, 8'h01);
        step(2'b00, 0, 0, 0, 0, '0);
        // R5 / R7: slave with run-in-standby, irq ignored, rx_done wakes
        step(2'b10, 1, 0, 0, 0, 8'h40);
        step(2'b10, 1, 0, 0, 1, 8'h40);
        step(2'b10, 1, 0, 0, 0, '0);
        // R6 / R8: master idle irq held three cycles gives one pulse
        step(2'b00, 0, 1, 0, 0, '0);
        step(2'b01, 0, 1, 0, 0, 8'h10);
        step(2'b01, 0, 1, 0, 0, 8'h10, "R8");
        step(2'b01, 0, 1, 0, 0, 8'h90, "R8");
        step(2'b01, 0, 1, 0, 0, '0);
        step(2'b10, 0, 1, 0, 0, 8'h02);
        // R1: reserved mode code behaves as active
        step(2'b11, 0, 0, 0, 1, 8'hff);
        step(2'b10, 0, 0, 0, 0, '0);
        step(2'b11, 0, 0, 0, 0, '0);

        // random mix over all codes and roles
        for (int i = 0; i < 4000; i++) begin
            step(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), (($urandom % 4) == 0) ? IRQ_W'($urandom) : '0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule